// File: doc/BRIEF.md
# Display Row Driver Parameter Interface

This block is the host-facing side of a dot-matrix display row driver. It is an 8-bit parallel slave port with active-low chip select, read and write strobes, and a register-select line. The port is sampled synchronously on the system clock. Every write takes effect at the trailing edge of its strobe, which is the first sampled cycle in which chip select or write is no longer low.

The host first writes a command byte with register select high. This byte names one of five parameter registers: operating mode, horizontal pitch, horizontal byte count, duty (time division) and contrast/bias. Each later write with register select low stores its byte into the register that was named. A busy indication runs for a fixed number of clocks after each data write, and data writes made during that time are dropped. The host reads the busy indication back on the top data bit. Every register field drives the display timing logic directly as an output. The block also gives the bias divisor in decoded form.

Top module: `lcd_row_regif`

## Requirements
- R1: A write with rs_i=1 loads the whole byte into the command pointer at the trailing edge of the strobe. The pointer keeps that value through any number of data writes until the next command write.
- R2: Pointer 00h selects the mode register. Data bit 0 drives ctrl_run_o, bit 1 drives disp_on_o, bit 2 drives standby_o, bit 3 drives scan_fwd_o, and bits 6:4 drive clk_div_o.
- R3: Pointer 01h selects the pitch register. Bit 7 drives pwr_opamp_o, bit 6 drives ladder_low_o, and bits 2:0 drive pitch_m1_o (pitch minus one).
- R4: Pointer 02h stores bits 3:0 to count_m1_o (byte count minus one). Pointer 03h stores bits 6:0 to duty_m1_o (duty minus one).
- R5: Pointer 04h stores bits 7:6 to bias_sel_o, bit 5 to boost_dbl_o and bits 4:0 to contrast_o. bias_div_o decodes bias_sel_o as 00→5, 01→5, 10→7, 11→9.
- R6: After a pointer above 04h is written, data writes change no output field.
- R7: While cs_ni and rd_ni are both low, data_oe_o is 1. With rs_i=1 the read returns data_o = {busy, 7'b0}; with rs_i=0 it returns 00h. While not reading, data_oe_o=0 and data_o=00h.
- R8: An accepted data write makes busy read as 1 for exactly BUSY_CYCLES clocks after the commit edge, then 0. A command write does not set busy.
- R9: A data write that commits while busy is 1 is dropped. A command write that commits while busy is 1 is still accepted.
- R10: After reset every field output is 0, busy is 0 and data_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rs_i | input | 1 | Register select: 1 command/busy, 0 data |
| data_i | input | 8 | Write data bus |
| data_o | output | 8 | Read data bus |
| data_oe_o | output | 1 | Read data enable |
| ctrl_run_o | output | 1 | Controller run |
| disp_on_o | output | 1 | Display enable |
| standby_o | output | 1 | Standby request |
| scan_fwd_o | output | 1 | Scan direction, 1 = first row to last |
| clk_div_o | output | 3 | Display clock divider select |
| pwr_opamp_o | output | 1 | Display supplies via buffers |
| ladder_low_o | output | 1 | Low-resistance ladder select |
| pitch_m1_o | output | 3 | Bits per byte minus one |
| count_m1_o | output | 4 | Horizontal bytes minus one |
| duty_m1_o | output | 7 | Time divisions minus one |
| bias_sel_o | output | 2 | Raw bias code |
| bias_div_o | output | 4 | Decoded bias divisor |
| boost_dbl_o | output | 1 | 1 = doubler, 0 = tripler |
| contrast_o | output | 5 | Contrast resistor step |

## Verification
Every pointer value from 00h to 07h is swept with the data bytes 00h, FFh, A5h, 5Ah and a walking-one pattern. The sweep shows whether each field lands on its own bits and whether any register picks up bits meant for another. Pointers 05h to 07h show whether out-of-range codes leak into a real register. Back-to-back data writes, and a command write placed inside the busy window, separate the busy lockout from the command path. Sampling busy once per cycle after a write confirms the length of the window. All four bias codes are decoded.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned NUM_REGS = 5;

  typedef enum logic [DW-1:0] {
    PTR_MODE     = 8'h00,
    PTR_PITCH    = 8'h01,
    PTR_COUNT    = 8'h02,
    PTR_DUTY     = 8'h03,
    PTR_CONTRAST = 8'h04
  } ptr_e;

  function automatic logic [3:0] bias_divisor(input logic [1:0] code);
    case (code)
      2'b10:   return 4'd7;
      2'b11:   return 4'd9;
      default: return 4'd5;
    endcase
  endfunction
endpackage

// File: rtl/lcd_regif_strobe.sv
module lcd_regif_strobe
  import lcd_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          wr_ni,
  input  logic          rs_i,
  input  logic [DW-1:0] data_i,
  output logic          cmd_we_o,
  output logic          dat_we_o,
  output logic [DW-1:0] wdata_o
);
  logic          wr_act, wr_act_q, rs_q, commit;
  logic [DW-1:0] dat_q;

  assign wr_act = ~cs_ni & ~wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rs_q     <= 1'b0;
      dat_q    <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act) begin
        rs_q  <= rs_i;
        dat_q <= data_i;
      end
    end
  end

  // commit on trailing edge of the strobe window
  assign commit   = wr_act_q & ~wr_act;
  assign cmd_we_o = commit & rs_q;
  assign dat_we_o = commit & ~rs_q;
  assign wdata_o  = dat_q;
endmodule

// File: rtl/lcd_regif_busy.sv
module lcd_regif_busy #(
  parameter int unsigned BUSY_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lcd_regif_regs.sv
module lcd_regif_regs
  import lcd_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] pitch_o,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] duty_o,
  output logic [DW-1:0] contrast_o
);
  localparam logic [DW-1:0] KEEP_MASK [NUM_REGS] =
    '{8'h7F, 8'hC7, 8'h0F, 8'h7F, 8'hFF};

  logic [DW-1:0] ptr_q;
  logic [DW-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (cmd_we_i) ptr_q <= wdata_i;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic sel;
    assign sel = dat_we_i && (ptr_q == DW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[g] <= '0;
      else if (sel) regs_q[g] <= wdata_i & KEEP_MASK[g];
    end
  end

  assign mode_o     = regs_q[PTR_MODE];
  assign pitch_o    = regs_q[PTR_PITCH];
  assign count_o    = regs_q[PTR_COUNT];
  assign duty_o     = regs_q[PTR_DUTY];
  assign contrast_o = regs_q[PTR_CONTRAST];
endmodule

// File: rtl/lcd_row_regif.sv
module lcd_row_regif
  import lcd_regif_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          rs_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          ctrl_run_o,
  output logic          disp_on_o,
  output logic          standby_o,
  output logic          scan_fwd_o,
  output logic [2:0]    clk_div_o,
  output logic          pwr_opamp_o,
  output logic          ladder_low_o,
  output logic [2:0]    pitch_m1_o,
  output logic [3:0]    count_m1_o,
  output logic [6:0]    duty_m1_o,
  output logic [1:0]    bias_sel_o,
  output logic [3:0]    bias_div_o,
  output logic          boost_dbl_o,
  output logic [4:0]    contrast_o
);
  logic          cmd_we, dat_we, dat_acc, busy;
  logic [DW-1:0] wdata;
  logic [DW-1:0] r_mode, r_pitch, r_count, r_duty, r_con;
  logic [5*DW-1:0] fields_w;

  lcd_regif_strobe u_strobe (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .rs_i, .data_i,
    .cmd_we_o (cmd_we),
    .dat_we_o (dat_we),
    .wdata_o  (wdata)
  );

  assign dat_acc = dat_we & ~busy;

  lcd_regif_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni,
    .start_i (dat_acc),
    .busy_o  (busy)
  );

  lcd_regif_regs u_regs (
    .clk_i, .rst_ni,
    .cmd_we_i   (cmd_we),
    .dat_we_i   (dat_acc),
    .wdata_i    (wdata),
    .mode_o     (r_mode),
    .pitch_o    (r_pitch),
    .count_o    (r_count),
    .duty_o     (r_duty),
    .contrast_o (r_con)
  );

  assign data_oe_o = ~cs_ni & ~rd_ni;
  assign data_o    = (data_oe_o && rs_i) ? {busy, 7'b0} : '0;

  assign ctrl_run_o   = r_mode[0];
  assign disp_on_o    = r_mode[1];
  assign standby_o    = r_mode[2];
  assign scan_fwd_o   = r_mode[3];
  assign clk_div_o    = r_mode[6:4];
  assign pwr_opamp_o  = r_pitch[7];
  assign ladder_low_o = r_pitch[6];
  assign pitch_m1_o   = r_pitch[2:0];
  assign count_m1_o   = r_count[3:0];
  assign duty_m1_o    = r_duty[6:0];
  assign bias_sel_o   = r_con[7:6];
  assign boost_dbl_o  = r_con[5];
  assign contrast_o   = r_con[4:0];
  assign bias_div_o   = bias_divisor(r_con[7:6]);

  assign fields_w = {r_mode, r_pitch, r_count, r_duty, r_con};
endmodule

module lcd_row_regif_chk #(
  parameter int unsigned BUSY_CYCLES = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        rd_ni,
  input logic        rs_i,
  input logic [7:0]  data_o,
  input logic        data_oe_o,
  input logic        busy,
  input logic        cmd_we,
  input logic        dat_we,
  input logic        dat_acc,
  input logic [39:0] fields_w
);
  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  a_r8_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_acc |=> busy);
  a_r8_cmd_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && !busy) |=> !busy);
  a_r8_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= BUSY_CYCLES);
  a_r9_drop_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we && busy) |=> $stable(fields_w));
  a_r1_cmd_keeps_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && !dat_we) |=> $stable(fields_w));
  a_r7_oe_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni) |-> data_oe_o);
  a_r7_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 8'h00));
  a_r7_busy_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_acc && !cs_ni && !rd_ni && rs_i) |=> (!cs_ni && !rd_ni && rs_i) -> data_o[7]);
endmodule

bind lcd_row_regif lcd_row_regif_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .rs_i, .data_o, .data_oe_o,
  .busy, .cmd_we, .dat_we, .dat_acc, .fields_w
);

// File: tb/tb_lcd_row_regif.sv
module tb_lcd_row_regif;
  localparam int BUSY = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, rs_i = 1'b0;
  logic [7:0] data_i = '0, data_o;
  logic data_oe_o, ctrl_run_o, disp_on_o, standby_o, scan_fwd_o;
  logic pwr_opamp_o, ladder_low_o, boost_dbl_o;
  logic [2:0] clk_div_o, pitch_m1_o;
  logic [3:0] count_m1_o, bias_div_o;
  logic [6:0] duty_m1_o;
  logic [1:0] bias_sel_o;
  logic [4:0] contrast_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_reg [5];
  logic [7:0] m_ptr;

  always #4 clk_i = ~clk_i;

  lcd_row_regif #(.BUSY_CYCLES(BUSY)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr_byte(input logic rs, input logic [7:0] d);
    cs_ni = 1'b0; wr_ni = 1'b0; rs_i = rs; data_i = d;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
    @(negedge clk_i);
  endtask

  function automatic logic [3:0] exp_div(input logic [1:0] c);
    return (c == 2'b10) ? 4'd7 : (c == 2'b11) ? 4'd9 : 4'd5;
  endfunction

  task automatic chk_fields(input string req);
    chk({req, " mode"}, {scan_fwd_o, standby_o, disp_on_o, ctrl_run_o, clk_div_o},
        {m_reg[0][3:0], m_reg[0][6:4]});
    chk({req, " pitch"}, {pwr_opamp_o, ladder_low_o, pitch_m1_o},
        {m_reg[1][7:6], m_reg[1][2:0]});
    chk({req, " count/duty"}, {count_m1_o, duty_m1_o}, {m_reg[2][3:0], m_reg[3][6:0]});
    chk({req, " contrast"}, {bias_sel_o, boost_dbl_o, contrast_o, bias_div_o},
        {m_reg[4], exp_div(m_reg[4][7:6])});
  endtask

  function automatic logic [7:0] busy_read();
    return data_o;
  endfunction

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pats [5];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01};
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    m_ptr = '0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R10 reset state
    chk_fields("R10");
    chk("R10 oe", data_oe_o, 0);
    cs_ni = 1'b0; rd_ni = 1'b0; rs_i = 1'b1; #1;
    chk("R10 busy", busy_read(), 8'h00);
    cs_ni = 1'b1; rd_ni = 1'b1; idle(1);

    // R2 R3 R4 R5 R6 sweep of pointers and patterns
    for (int p = 0; p < 8; p++) begin
      wr_byte(1'b1, 8'(p));
      m_ptr = 8'(p);
      for (int k = 0; k < 12; k++) begin
        logic [7:0] d;
        d = (k < 5) ? pats[k] : (8'h01 << (k - 4));
        wr_byte(1'b0, d);
        idle(BUSY + 1);
        case (p)
          0: m_reg[0] = d & 8'h7F;
          1: m_reg[1] = d & 8'hC7;
          2: m_reg[2] = d & 8'h0F;
          3: m_reg[3] = d & 8'h7F;
          4: m_reg[4] = d;
          default: ;
        endcase
        chk_fields((p > 4) ? "R6" : (p == 0) ? "R2" : (p == 1) ? "R3" :
                   (p == 4) ? "R5" : "R4");
      end
    end

    // R1 pointer holds across data writes
    wr_byte(1'b1, 8'h02);
    wr_byte(1'b0, 8'h03); idle(BUSY + 1);
    wr_byte(1'b0, 8'h09); idle(BUSY + 1);
    m_reg[2] = 8'h09;
    chk_fields("R1");

    // R8 busy window length
    wr_byte(1'b1, 8'h03);
    cs_ni = 1'b0; rd_ni = 1'b0; rs_i = 1'b1; #1;
    chk("R8 no busy after command", busy_read(), 8'h00);
    cs_ni = 1'b1; rd_ni = 1'b1;
    idle(1);
    wr_byte(1'b0, 8'h40); m_reg[3] = 8'h40;
    for (int c = 0; c <= BUSY; c++) begin
      cs_ni = 1'b0; rd_ni = 1'b0; rs_i = 1'b1; #1;
      chk("R8 busy window", busy_read(), (c < BUSY) ? 8'h80 : 8'h00);
      chk("R7 oe", data_oe_o, 1);
      @(negedge clk_i);
    end
    rs_i = 1'b0; #1;
    chk("R7 rs0 read", data_o, 8'h00);
    cs_ni = 1'b1; rd_ni = 1'b1; #1;
    chk("R7 idle bus", {data_oe_o, data_o}, 9'h000);
    idle(1);

    // R9 back-to-back data writes: second dropped
    wr_byte(1'b1, 8'h00);
    wr_byte(1'b0, 8'h55);
    wr_byte(1'b0, 8'h2A);
    idle(BUSY + 1);
    m_reg[0] = 8'h55;
    chk_fields("R9 drop");

    // R9 command accepted during busy
    wr_byte(1'b0, 8'h11);
    wr_byte(1'b1, 8'h04);
    idle(BUSY + 1);
    m_reg[0] = 8'h11;
    wr_byte(1'b0, 8'hC3);
    idle(BUSY + 1);
    m_reg[4] = 8'hC3;
    chk_fields("R9 cmd");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule